// File: doc/BRIEF.md
# Hold-Mode Wake and Event Controller

This block gathers single-cycle event pulses from the timing and I/O sources of a small processor core (divider overflows, timer underflows, input-port pin changes, external falling edges and serial completion) into sticky per-source event flags. Software owns three mask vectors that it drives into the block: an interrupt enable per source, a global interrupt enable, and a hold-release enable per source. Interrupt requests are the event flags gated by both interrupt enables.

The block also owns the core's low-power hold state. A hold-entry strobe puts it into hold and clears the release-cause flags. While in hold, a new pulse from any source whose release enable is set brings the core back to run and records which sources woke it. A new pulse from a source enabled only for interrupts leaves hold just long enough to service that interrupt. When the core signals that the service routine is complete, the block returns to hold on its own. Pin changes on the two four-pin input ports count only on pins whose port-enable bit is set. All pins are plain level or strobe signals. The block has no streaming data path, so it has no valid/ready handshake.

Top module: `hwk_ctrl`

## Requirements
- R1: After reset, the event flags, the cause flags and the interrupt requests are all zero, and both `hold_o` and `svc_o` are low.
- R2: A pulse on an event source sets that source's event flag on the next clock edge. The flag then stays set until it is cleared.
- R3: When `evf_clr_i` is high, every event flag whose bit is set in `evf_clr_mask_i` is cleared on the next edge. If a set and a clear hit the same flag in the same cycle, the set wins.
- R4: Source index 2 is port A and source index 8 is port B. Each port's pulse is the OR of its pin-change inputs, with each pin gated by its enable bit in `pa_en_i` or `pb_en_i`. The `src_pulse_i` bits at indices 2 and 8 are ignored.
- R5: `irq_o[n]` is high exactly when event flag n, `ien_i[n]` and `gie_i` are all high.
- R6: A `hold_enter_i` strobe while running raises `hold_o` on the next edge and clears all cause flags on that same edge.
- R7: While in hold or in service, a pulse from a source whose release enable is set returns the block to run on the next edge. The same edge sets that source's cause flag. `hen_i` covers indices 0 to 7 and `hen_pb_i` covers index 8. Index 0 is divider 0, 1 is timer 0, 2 is port A, 3 is the falling edge on interrupt pin 0, and 8 is port B.
- R8: While in hold, a pulse that is neither release-enabled nor interrupt-enabled keeps `hold_o` high. It still sets the event flag.
- R9: While in hold, a pulse that is interrupt-enabled (its `ien_i` bit and `gie_i` both high) but not release-enabled drops `hold_o` and raises `svc_o` on the next edge. A later `svc_done_i` returns the block to hold on the next edge, and the cause flags stay unchanged.
- R10: While running, cause flags hold their value, even when release-enabled pulses arrive.
- R11: `hold_enter_i` has no effect while the block is in hold or in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse_i | input | 9 | Event pulses by source index; indices 2 and 8 are ignored |
| pa_chg_i | input | 4 | Port A pin-change pulses |
| pa_en_i | input | 4 | Port A per-pin enables |
| pb_chg_i | input | 4 | Port B pin-change pulses |
| pb_en_i | input | 4 | Port B per-pin enables |
| ien_i | input | 9 | Per-source interrupt enables |
| gie_i | input | 1 | Global interrupt enable |
| hen_i | input | 8 | Release enables for sources 0 to 7 |
| hen_pb_i | input | 1 | Release enable for port B (source 8) |
| evf_clr_i | input | 1 | Event-flag clear strobe |
| evf_clr_mask_i | input | 9 | Mask of event flags to clear |
| hold_enter_i | input | 1 | Hold-entry strobe |
| svc_done_i | input | 1 | Interrupt service complete strobe |
| evf_o | output | 9 | Event flags |
| cause_o | output | 9 | Hold-release cause flags |
| irq_o | output | 9 | Interrupt requests |
| hold_o | output | 1 | Core is held |
| svc_o | output | 1 | Temporarily released to service an interrupt |

## Verification
Every piece of internal state reaches a port within one clock edge. A wrong event flag appears on `evf_o` and `irq_o` in the cycle after the pulse or clear. A wrong hold state shows on `hold_o` or `svc_o` one edge after the strobe or pulse that should have moved it. Corrupted cause flags are visible on `cause_o` right after a wake, and again after an unrelated release-enabled pulse while running. The hardest errors to catch are a return to run instead of to hold after service, and port pins counted without their enable bit. Both get dedicated scenarios.

// File: rtl/hwk_pkg.sv
package hwk_pkg;
  typedef enum logic [1:0] {
    HS_RUN  = 2'd0,
    HS_HOLD = 2'd1,
    HS_SVC  = 2'd2
  } hold_st_e;
endpackage

// File: rtl/hwk_pin_qual.sv
module hwk_pin_qual #(
  parameter int PINS = 4
) (
  input  logic [PINS-1:0] chg_i,
  input  logic [PINS-1:0] en_i,
  output logic            hit_o
);
  logic [PINS-1:0] gated;

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    assign gated[p] = chg_i[p] & en_i[p];
  end

  assign hit_o = |gated;
endmodule

// File: rtl/hwk_flag_bank.sv
module hwk_flag_bank #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        flags_o[g] <= 1'b0;
      else if (set_i[g])                 flags_o[g] <= 1'b1;
      else if (clr_i && clr_mask_i[g])   flags_o[g] <= 1'b0;
    end

    // R2
    evf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_o[g]) |-> $past(set_i[g]));

    // R3
    evf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && clr_mask_i[g] && !set_i[g]) |=> !flags_o[g]);
  end
endmodule

// File: rtl/hwk_hold_fsm.sv
module hwk_hold_fsm
  import hwk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hold_enter_i,
  input  logic     wake_i,
  input  logic     int_hit_i,
  input  logic     svc_done_i,
  output hold_st_e state_o,
  output logic     entering_o,
  output logic     hold_o,
  output logic     svc_o
);
  hold_st_e nxt;

  always_comb begin
    nxt = state_o;
    unique case (state_o)
      HS_RUN:  if (hold_enter_i) nxt = HS_HOLD;
      HS_HOLD: begin
        if (wake_i)         nxt = HS_RUN;
        else if (int_hit_i) nxt = HS_SVC;
      end
      HS_SVC: begin
        if (wake_i)          nxt = HS_RUN;
        else if (svc_done_i) nxt = HS_HOLD;
      end
      default: nxt = HS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_o <= HS_RUN;
    else        state_o <= nxt;
  end

  assign entering_o = (state_o == HS_RUN) && hold_enter_i;
  assign hold_o     = (state_o == HS_HOLD);
  assign svc_o      = (state_o == HS_SVC);

  // R7
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && wake_i) |=> (!hold_o && !svc_o));

  // R9
  svc_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && int_hit_i && !wake_i) |=> svc_o);

  // R9
  svc_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_o && svc_done_i && !wake_i) |=> hold_o);

  // R11
  reenter_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && hold_enter_i && !wake_i && !int_hit_i) |=> hold_o);
endmodule

// File: rtl/hwk_ctrl.sv
module hwk_ctrl
  import hwk_pkg::*;
#(
  parameter int NUM_MAIN = 8,
  parameter int PORT_PINS = 4,
  parameter int PA_IDX = 2,
  localparam int NSRC = NUM_MAIN + 1,
  localparam int PB_IDX = NUM_MAIN
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      src_pulse_i,
  input  logic [PORT_PINS-1:0] pa_chg_i,
  input  logic [PORT_PINS-1:0] pa_en_i,
  input  logic [PORT_PINS-1:0] pb_chg_i,
  input  logic [PORT_PINS-1:0] pb_en_i,
  input  logic [NSRC-1:0]      ien_i,
  input  logic                 gie_i,
  input  logic [NUM_MAIN-1:0]  hen_i,
  input  logic                 hen_pb_i,
  input  logic                 evf_clr_i,
  input  logic [NSRC-1:0]      evf_clr_mask_i,
  input  logic                 hold_enter_i,
  input  logic                 svc_done_i,
  output logic [NSRC-1:0]      evf_o,
  output logic [NSRC-1:0]      cause_o,
  output logic [NSRC-1:0]      irq_o,
  output logic                 hold_o,
  output logic                 svc_o
);
  logic            pa_hit, pb_hit;
  logic [NSRC-1:0] evt;
  logic [NSRC-1:0] hen_all;
  logic [NSRC-1:0] wake_vec;
  logic            wake, int_hit, entering;
  hold_st_e        st;

  hwk_pin_qual #(.PINS(PORT_PINS)) u_pa (
    .chg_i(pa_chg_i), .en_i(pa_en_i), .hit_o(pa_hit));
  hwk_pin_qual #(.PINS(PORT_PINS)) u_pb (
    .chg_i(pb_chg_i), .en_i(pb_en_i), .hit_o(pb_hit));

  always_comb begin
    evt         = src_pulse_i;
    evt[PA_IDX] = pa_hit;
    evt[PB_IDX] = pb_hit;
  end

  assign hen_all  = {hen_pb_i, hen_i};
  assign wake_vec = evt & hen_all;
  assign wake     = |wake_vec;
  assign int_hit  = gie_i & (|(evt & ien_i));

  hwk_flag_bank #(.N(NSRC)) u_evf (
    .clk(clk), .rst_n(rst_n), .set_i(evt), .clr_i(evf_clr_i),
    .clr_mask_i(evf_clr_mask_i), .flags_o(evf_o));

  hwk_hold_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .hold_enter_i(hold_enter_i), .wake_i(wake),
    .int_hit_i(int_hit), .svc_done_i(svc_done_i), .state_o(st),
    .entering_o(entering), .hold_o(hold_o), .svc_o(svc_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cause_o <= '0;
    else if (entering)     cause_o <= '0;
    else if (st != HS_RUN) cause_o <= cause_o | wake_vec;
  end

  assign irq_o = evf_o & ien_i & {NSRC{gie_i}};

  // R6
  cause_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_RUN && hold_enter_i) |=> (cause_o == '0 && hold_o));

  // R10
  cause_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_RUN && !hold_enter_i) |=> $stable(cause_o));

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |-> (irq_o == '0));
endmodule

// File: tb/hwk_ctrl_test.sv
module hwk_ctrl_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] src_pulse = '0;
  logic [3:0] pa_chg = '0, pa_en = '0, pb_chg = '0, pb_en = '0;
  logic [8:0] ien = '0;
  logic       gie = 1'b0;
  logic [7:0] hen = '0;
  logic       hen_pb = 1'b0;
  logic       clr = 1'b0;
  logic [8:0] clr_mask = '0;
  logic       hold_enter = 1'b0, svc_done = 1'b0;
  logic [8:0] evf, cause, irq;
  logic       hold, svc;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  hwk_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_pulse_i(src_pulse),
    .pa_chg_i(pa_chg), .pa_en_i(pa_en), .pb_chg_i(pb_chg), .pb_en_i(pb_en),
    .ien_i(ien), .gie_i(gie), .hen_i(hen), .hen_pb_i(hen_pb),
    .evf_clr_i(clr), .evf_clr_mask_i(clr_mask),
    .hold_enter_i(hold_enter), .svc_done_i(svc_done),
    .evf_o(evf), .cause_o(cause), .irq_o(irq), .hold_o(hold), .svc_o(svc));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Strobe inputs stay applied for one edge and are dropped at the next falling edge.
  task automatic cyc();
    @(negedge clk);
    src_pulse = '0; pa_chg = '0; pb_chg = '0;
    clr = 1'b0; hold_enter = 1'b0; svc_done = 1'b0;
  endtask

  task automatic clear_all();
    clr = 1'b1; clr_mask = 9'h1FF; cyc();
  endtask

  task automatic t_reset();
    chk("R1 evf", evf, 0);
    chk("R1 cause", cause, 0);
    chk("R1 irq", irq, 0);
    chk("R1 hold", hold, 0);
    chk("R1 svc", svc, 0);
  endtask

  task automatic t_set();
    src_pulse = 9'h001; cyc();
    chk("R2 set div", evf, 9'h001);
    src_pulse = 9'h020; cyc();
    chk("R2 set second", evf, 9'h021);
    cyc();
    chk("R2 sticky", evf, 9'h021);
  endtask

  task automatic t_clear();
    clr = 1'b1; clr_mask = 9'h001; cyc();
    chk("R3 mask clear", evf, 9'h020);
    clr = 1'b1; clr_mask = 9'h020; src_pulse = 9'h020; cyc();
    chk("R3 set beats clear", evf, 9'h020);
  endtask

  task automatic t_irq();
    ien = 9'h020; gie = 1'b0; #1;
    chk("R5 gie off", irq, 0);
    gie = 1'b1; #1;
    chk("R5 gie on", irq, 9'h020);
    ien = 9'h001; #1;
    chk("R5 ien off", irq, 0);
    ien = '0; gie = 1'b0;
    clear_all();
  endtask

  task automatic t_port();
    pa_en = 4'b0011; pa_chg = 4'b0100; cyc();
    chk("R4 pa disabled pin", evf, 0);
    pa_en = 4'b0100; pa_chg = 4'b0100; cyc();
    chk("R4 pa enabled pin", evf, 9'h004);
    clear_all();
    src_pulse = 9'h104; cyc();
    chk("R4 raw port bits ignored", evf, 0);
    pb_en = 4'b1000; pb_chg = 4'b1001; cyc();
    chk("R4 pb enabled pin", evf, 9'h100);
    clear_all();
  endtask

  task automatic t_hold_wake();
    hold_enter = 1'b1; cyc();
    chk("R6 enter hold", hold, 1);
    chk("R6 cause clear", cause, 0);
    src_pulse = 9'h001; cyc();
    chk("R8 stays held", hold, 1);
    chk("R8 evf set", evf, 9'h001);
    hold_enter = 1'b1; cyc();
    chk("R11 enter ignored hold", hold, 1);
    chk("R11 enter ignored svc", svc, 0);
    hen = 8'h02; src_pulse = 9'h002; cyc();
    chk("R7 wake", hold, 0);
    chk("R7 cause tmr0", cause, 9'h002);
    hen = 8'h01; src_pulse = 9'h001; cyc();
    chk("R10 cause held in run", cause, 9'h002);
    hold_enter = 1'b1; cyc();
    chk("R6 re-entry clears cause", cause, 0);
    hen = '0; hen_pb = 1'b1; pb_en = 4'b0010; pb_chg = 4'b0010; cyc();
    chk("R7 pb wake", hold, 0);
    chk("R7 cause pb", cause, 9'h100);
    hen_pb = 1'b0;
    clear_all();
  endtask

  task automatic t_service();
    hold_enter = 1'b1; cyc();
    chk("R9 held", hold, 1);
    gie = 1'b1; ien = 9'h008; src_pulse = 9'h008; cyc();
    chk("R9 svc raised", svc, 1);
    chk("R9 hold dropped", hold, 0);
    chk("R9 irq", irq, 9'h008);
    hold_enter = 1'b1; cyc();
    chk("R11 enter ignored in svc", svc, 1);
    svc_done = 1'b1; cyc();
    chk("R9 back to hold", hold, 1);
    chk("R9 svc low", svc, 0);
    chk("R9 cause untouched", cause, 0);
    hen = 8'h08; src_pulse = 9'h008; cyc();
    chk("R7 int0 edge wake", cause, 9'h008);
    chk("R7 run after wake", hold | svc, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_set();
    t_clear();
    t_irq();
    t_port();
    t_hold_wake();
    t_service();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule